// File: doc/BRIEF.md
# Left-Justified Serial Audio Receiver

This block takes the three-wire serial audio stream of an audio ADC: a bit clock, a word-select line and a serial data line. The framing is left-justified, so a word's most significant bit shares its bit-clock period with the word-select change that opens the slot. Each slot yields one `WORD_W`-bit word. The word is tagged with the channel that the word-select level names, and it is offered on a valid/ready stream toward a FIFO or DMA engine in the system clock domain.

Bits are captured on the rising bit-clock edge. A finished word is written in that same edge into a small asynchronous buffer with Gray-coded pointers. The buffer is drained at once into a single output register in the system domain. That register holds its word until the consumer accepts it. If a newer word reaches the register while it is still occupied, the newer word is discarded and a sticky overrun flag is raised. Only a dedicated clear input lowers the flag.

Top module: `i2s_lj_rx`

## Requirements
- R1: Data is MSB first. On a rising bit-clock edge where the sampled word select differs from its previous sample, the sampled data bit becomes bit `WORD_W-1`. The next `WORD_W-1` rising edges fill the word down to bit 0.
- R2: `tchan_o` carries the word-select level of the slot the word came from: 0 when word select was low, 1 when it was high.
- R3: `tvalid_o` is never raised for a word until all `WORD_W` bits of that word have been sampled. Stopping the bit clock after `WORD_W-1` bits produces no output word.
- R4: While `tvalid_o` is high and `tready_i` is low, `tvalid_o`, `tdata_o` and `tchan_o` stay constant. The word is transferred on a system clock edge with both high, and `tvalid_o` then falls unless another word is waiting.
- R5: After reset, bits seen before the first word-select change are discarded. Any number of them produces no word.
- R6: After reset, `tvalid_o`, `tdata_o` and `overrun_o` are 0. `tdata_o` is always driven and keeps the last accepted word after the transfer. It changes only when a new word is presented.
- R7: A word that reaches the output while an earlier word is still waiting with `tready_i` low is dropped. The waiting word is kept, and `overrun_o` is set and stays set.
- R8: A high `ovr_clr_i` on a system clock edge clears `overrun_o`.
- R9: Bit-clock periods in a slot after the `WORD_W`-th bit are ignored. Slots longer than a word give the same output as slots of exactly `WORD_W` bits.
- R10: With `tready_i` toggling while words arrive no faster than the consumer accepts them, every word is delivered once, in order, and `overrun_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| sck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word select (channel level) |
| sd_i | input | 1 | Serial data |
| tdata_o | output | WORD_W | Received word |
| tchan_o | output | 1 | Channel tag, 0 = word select low, 1 = high |
| tvalid_o | output | 1 | Word available |
| tready_i | input | 1 | Consumer accepts word |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| overrun_o | output | 1 | Sticky dropped-word flag |

## Verification
The bench builds the receiver with `WORD_W = 8` and a two-entry buffer. At this width every one of the 256 data codes can be sent through both channels, with slot lengths stretched by zero to two extra bits. Short slots also keep the cases that need exact bit timing cheap to set up: a word stopped one bit short, a stream that begins in the middle of a slot, and a second word arriving behind one held by backpressure.

// File: rtl/i2s_lj_pkg.sv
package i2s_lj_pkg;
  typedef enum logic {
    CH_WS_LOW  = 1'b0,
    CH_WS_HIGH = 1'b1
  } chan_e;
endpackage

// File: rtl/i2s_lj_sync.sv
module i2s_lj_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/i2s_lj_deser.sv
module i2s_lj_deser
  import i2s_lj_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic            sck_i,
  input  logic            rst_ni,
  input  logic            ws_i,
  input  logic            sd_i,
  output logic            word_vld_o,
  output logic [WORD_W:0] word_o
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(WORD_W - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(WORD_W);

  logic              hist_vld_q;
  logic              ws_q;
  logic              active_q;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-2:0] sh_q;
  chan_e             chan_q;
  logic              ws_edge;

  // first sample only seeds history: no edge can be seen mid-slot after reset
  assign ws_edge = hist_vld_q && (ws_i != ws_q);

  // completion is combinational so the word lands on the edge of its last bit
  assign word_vld_o = active_q && !ws_edge && (cnt_q == LAST_IDX);
  assign word_o     = {chan_q, sh_q, sd_i};

  always_ff @(posedge sck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_vld_q <= 1'b0;
      ws_q       <= 1'b0;
      active_q   <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
      chan_q     <= CH_WS_LOW;
    end else begin
      hist_vld_q <= 1'b1;
      ws_q       <= ws_i;
      if (ws_edge) begin
        active_q <= 1'b1;
        cnt_q    <= CW'(1);
        sh_q     <= (WORD_W-1)'(sd_i);
        chan_q   <= chan_e'(ws_i);
      end else if (active_q && (cnt_q < FULL_CNT)) begin
        cnt_q <= cnt_q + CW'(1);
        sh_q  <= {sh_q[WORD_W-3:0], sd_i};
      end
    end
  end
endmodule

// File: rtl/i2s_lj_cdc_fifo.sv
module i2s_lj_cdc_fifo #(
  parameter int DATA_W = 33,
  parameter int DEPTH  = 2
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rgray_w, wgray_r, rbin_w;
  logic          full, do_wr, do_rd;

  i2s_lj_sync #(.W(PW)) u_r2w (.clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rgray_w));
  i2s_lj_sync #(.W(PW)) u_w2r (.clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_r));

  assign rbin_w = from_gray(rgray_w);
  assign full   = (wbin_q[AW] != rbin_w[AW]) && (wbin_q[AW-1:0] == rbin_w[AW-1:0]);
  assign do_wr  = wr_en_i && !full;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (do_wr) begin
      wbin_q  <= wbin_q + PW'(1);
      wgray_q <= to_gray(wbin_q + PW'(1));
    end
  end

  always_ff @(posedge wclk_i) begin
    if (do_wr) mem[wbin_q[AW-1:0]] <= wdata_i;
  end

  assign empty_o = (rgray_q == wgray_r);
  assign do_rd   = rd_en_i && !empty_o;
  assign rdata_o = mem[rbin_q[AW-1:0]];

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (do_rd) begin
      rbin_q  <= rbin_q + PW'(1);
      rgray_q <= to_gray(rbin_q + PW'(1));
    end
  end
endmodule

// File: rtl/i2s_lj_out_stage.sv
module i2s_lj_out_stage #(
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              avail_i,
  input  logic [WORD_W:0]   entry_i,
  output logic              pop_o,
  output logic [WORD_W-1:0] tdata_o,
  output logic              tchan_o,
  output logic              tvalid_o,
  input  logic              tready_i,
  input  logic              ovr_clr_i,
  output logic              overrun_o
);
  logic load, drop;

  // buffer is always drained; a word that cannot be loaded is lost
  assign pop_o = avail_i;
  assign load  = avail_i && (!tvalid_o || tready_i);
  assign drop  = avail_i && tvalid_o && !tready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tvalid_o <= 1'b0;
      tdata_o  <= '0;
      tchan_o  <= 1'b0;
    end else if (load) begin
      tvalid_o <= 1'b1;
      tdata_o  <= entry_i[WORD_W-1:0];
      tchan_o  <= entry_i[WORD_W];
    end else if (tready_i) begin
      tvalid_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        overrun_o <= 1'b0;
    else if (drop)      overrun_o <= 1'b1;
    else if (ovr_clr_i) overrun_o <= 1'b0;
  end
endmodule

// File: rtl/i2s_lj_rx.sv
module i2s_lj_rx #(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  output logic [WORD_W-1:0] tdata_o,
  output logic              tchan_o,
  output logic              tvalid_o,
  input  logic              tready_i,
  input  logic              ovr_clr_i,
  output logic              overrun_o
);
  localparam int ENTRY_W = WORD_W + 1;

  logic               word_vld;
  logic [ENTRY_W-1:0] word;
  logic [ENTRY_W-1:0] entry;
  logic               empty, pop;

  i2s_lj_deser #(.WORD_W(WORD_W)) u_deser (
    .sck_i     (sck_i),
    .rst_ni    (rst_ni),
    .ws_i      (ws_i),
    .sd_i      (sd_i),
    .word_vld_o(word_vld),
    .word_o    (word)
  );

  i2s_lj_cdc_fifo #(.DATA_W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .wclk_i (sck_i),
    .rst_ni (rst_ni),
    .wr_en_i(word_vld),
    .wdata_i(word),
    .rclk_i (clk_i),
    .rd_en_i(pop),
    .rdata_o(entry),
    .empty_o(empty)
  );

  i2s_lj_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .avail_i  (!empty),
    .entry_i  (entry),
    .pop_o    (pop),
    .tdata_o  (tdata_o),
    .tchan_o  (tchan_o),
    .tvalid_o (tvalid_o),
    .tready_i (tready_i),
    .ovr_clr_i(ovr_clr_i),
    .overrun_o(overrun_o)
  );
endmodule

// File: rtl/i2s_lj_rx_chk.sv
module i2s_lj_rx_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] tdata_o,
  input logic              tchan_o,
  input logic              tvalid_o,
  input logic              tready_i,
  input logic              ovr_clr_i,
  input logic              overrun_o
);
  // R4
  hold_under_backpressure_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tvalid_o && !tready_i) |=> (tvalid_o && $stable(tdata_o) && $stable(tchan_o)));

  // R4
  valid_falls_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tvalid_o) |-> $past(tready_i));

  // R6
  data_moves_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tdata_o) |-> tvalid_o);

  // R7
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_i) |=> overrun_o);

  // R8
  overrun_clear_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(overrun_o) |-> $past(ovr_clr_i));
endmodule

bind i2s_lj_rx i2s_lj_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tdata_o  (tdata_o),
  .tchan_o  (tchan_o),
  .tvalid_o (tvalid_o),
  .tready_i (tready_i),
  .ovr_clr_i(ovr_clr_i),
  .overrun_o(overrun_o)
);

// File: tb/i2s_lj_rx_tb.sv
`timescale 1ns/1ps
module i2s_lj_rx_tb;
  localparam int W = 8;
  localparam int SCK_HALF = 100;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic tready = 1'b1, ovr_clr = 1'b0;
  logic [W-1:0] tdata;
  logic tchan, tvalid, overrun;

  i2s_lj_rx #(.WORD_W(W), .FIFO_DEPTH(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .tdata_o(tdata), .tchan_o(tchan), .tvalid_o(tvalid), .tready_i(tready),
    .ovr_clr_i(ovr_clr), .overrun_o(overrun)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  bit tog_en = 1'b0;

  logic [W-1:0] exp_d [0:1023];
  logic         exp_c [0:1023];
  logic [W-1:0] rec_d [0:1023];
  logic         rec_c [0:1023];
  int exp_n = 0, rec_n = 0, cmp_i = 0;

  always @(negedge clk) begin
    if (rst_n && tvalid && tready && rec_n < 1024) begin
      rec_d[rec_n] = tdata;
      rec_c[rec_n] = tchan;
      rec_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sck_bit(input logic w, input logic d);
    ws = w;
    sd = d;
    #SCK_HALF sck = 1'b1;
    #SCK_HALF sck = 1'b0;
  endtask

  task automatic send_slot(input logic w, input logic [W-1:0] d, input int extra);
    for (int i = W - 1; i >= 0; i--) sck_bit(w, d[i]);
    for (int i = 0; i < extra; i++) sck_bit(w, 1'b1);
  endtask

  task automatic expect_word(input logic [W-1:0] d, input logic c);
    exp_d[exp_n] = d;
    exp_c[exp_n] = c;
    exp_n++;
  endtask

  task automatic settle();
    repeat (30) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic compare_all(input string req);
    chk(rec_n == exp_n, req, rec_n, exp_n);
    while (cmp_i < exp_n && cmp_i < rec_n) begin
      chk(rec_d[cmp_i] == exp_d[cmp_i] && rec_c[cmp_i] == exp_c[cmp_i], req,
          {23'd0, rec_c[cmp_i], rec_d[cmp_i]}, {23'd0, exp_c[cmp_i], exp_d[cmp_i]});
      cmp_i++;
    end
    cmp_i = exp_n;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    chk(tvalid == 1'b0, "R6 reset valid", tvalid, 0);
    chk(tdata == '0, "R6 reset data", tdata, 0);
    chk(overrun == 1'b0, "R6 reset overrun", overrun, 0);

    // R5: stream joins mid-slot, longer than a word, no edge seen
    for (int i = 0; i < 10; i++) sck_bit(1'b1, 1'b1);
    settle();
    chk(rec_n == 0, "R5 no word before first edge", rec_n, 0);
    send_slot(1'b0, 8'h5A, 0); expect_word(8'h5A, 1'b0);
    send_slot(1'b1, 8'h81, 0); expect_word(8'h81, 1'b1);
    settle();
    compare_all("R5");

    // R1 R2 R9: all codes on both channels, slots stretched by 0..2 bits
    for (int v = 0; v < 256; v++) begin
      send_slot(1'b0, W'(v), v % 3);
      expect_word(W'(v), 1'b0);
      send_slot(1'b1, W'(v) ^ 8'hA5, (v + 1) % 3);
      expect_word(W'(v) ^ 8'hA5, 1'b1);
    end
    settle();
    compare_all("R1 R2 R9 sweep");

    // R3: one bit short, then the final bit
    for (int i = W - 1; i >= 1; i--) sck_bit(1'b0, 8'hB6 >> i);
    settle();
    chk(rec_n == exp_n, "R3 no word after W-1 bits", rec_n, exp_n);
    chk(tvalid == 1'b0, "R3 valid low mid-word", tvalid, 0);
    sck_bit(1'b0, 1'b0);
    expect_word(8'hB6, 1'b0);
    settle();
    compare_all("R3");

    // R4 R7 R8: backpressure, second word dropped
    @(posedge clk); #1 tready = 1'b0;
    send_slot(1'b1, 8'h3C, 0);
    settle();
    chk(tvalid == 1'b1, "R4 valid raised", tvalid, 1);
    chk(tdata == 8'h3C, "R4 data", tdata, 8'h3C);
    chk(tchan == 1'b1, "R2 chan high", tchan, 1);
    settle(); settle();
    chk(tvalid == 1'b1 && tdata == 8'h3C, "R4 held", tdata, 8'h3C);
    chk(overrun == 1'b0, "R7 no overrun yet", overrun, 0);
    send_slot(1'b0, 8'hC3, 0);
    settle();
    chk(tdata == 8'h3C && tchan == 1'b1, "R7 waiting word kept", tdata, 8'h3C);
    chk(overrun == 1'b1, "R7 overrun set", overrun, 1);
    settle();
    chk(overrun == 1'b1, "R7 overrun sticky", overrun, 1);
    @(posedge clk); #1 ovr_clr = 1'b1;
    @(posedge clk); #1 ovr_clr = 1'b0;
    @(negedge clk);
    chk(overrun == 1'b0, "R8 overrun cleared", overrun, 0);
    @(posedge clk); #1 tready = 1'b1;
    @(posedge clk); #1 tready = 1'b0;
    @(negedge clk);
    chk(tvalid == 1'b0, "R4 valid falls after transfer", tvalid, 0);
    chk(tdata == 8'h3C, "R6 data kept after transfer", tdata, 8'h3C);
    expect_word(8'h3C, 1'b1);
    settle();
    compare_all("R4 R7 only held word delivered");

    // R10: ready toggling
    tog_en = 1'b1;
    fork
      begin
        while (tog_en) begin
          @(posedge clk); #1 tready = ~tready;
        end
      end
    join_none
    for (int i = 0; i < 20; i++) begin
      send_slot((i % 2 == 0) ? 1'b1 : 1'b0, W'(i * 37 + 11), 0);
      expect_word(W'(i * 37 + 11), (i % 2 == 0) ? 1'b1 : 1'b0);
    end
    tog_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 tready = 1'b1;
    settle();
    compare_all("R10");
    chk(overrun == 1'b0, "R10 no overrun", overrun, 0);
    chk(tvalid == 1'b0 && tdata == W'(19 * 37 + 11), "R6 last word held", tdata, W'(19 * 37 + 11));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule